// File: doc/BRIEF.md
# Daisy-Chain Frame Codec with CRC-8

This block builds and checks the 32-bit words that a host exchanges with a chain of battery-monitor devices. On the transmit side it combines a device address, a register address, an 8-bit value and a broadcast flag into a complete write word. The word carries a CRC-8 and a fixed three-bit trailer. The transmit path is purely combinational, so the word is ready for a serializer in the same cycle as its fields.

On the receive side, a captured 32-bit word is presented together with a frame-done strobe and a layout select. The host sets the layout select because it knows whether it asked for a register readback or for conversion results. One cycle after the strobe, the block presents the following:
- a CRC verdict;
- an end-of-chain marker, raised for an all-zero word;
- the device address, restored to natural bit order;
- the address and value fields for the selected layout;
- a flag that marks cell-voltage results.

Serial shifting, clocking of the serial link and transaction sequencing are handled elsewhere.

Top module: `chain_frame_codec`

## Requirements
- R1: The CRC step is CRC-8 with polynomial 0x2F, processed MSB first from zero. For a 24-bit operand {b2,b1,b0}, the CRC is step(step(b2) ^ b1) ^ b0, where step(x) shifts x left eight times and XORs in 0x2F whenever the bit shifted out is 1. The write CRC sits in tx_word[10:3] and uses tx_word[31:11], zero-extended, as its operand.
- R2: tx_word holds the following fields:

  | Bits | Content |
  |------|---------|
  | [31:27] | tx_dev, unchanged |
  | [26:21] | tx_reg |
  | [20:13] | tx_data |
  | [12] | tx_bcast |
  | [11] | 0 |
  | [2:0] | 3'b010, not covered by the CRC |

- R3: A received word is accepted when rx_done is high. Its CRC is computed over rx_word[31:10] and compared with rx_word[9:2]. On a mismatch, rx_crc_err is 1.
- R4: With rx_regmode=0 (conversion layout):
  - rx_addr is {2'b00, rx_word[26:23]};
  - rx_value is rx_word[22:11];
  - rx_ack is 0.
- R5: With rx_regmode=1 (readback layout):
  - rx_addr is rx_word[26:21];
  - rx_value is {4'b0000, rx_word[20:13]};
  - rx_ack is rx_word[10].
- R6: The device field rx_word[31:27] arrives bit-reversed. rx_dev[i] equals rx_word[31-i] for i = 0..4.
- R7: rx_valid is high for exactly the one cycle after each cycle in which rx_done is high. All other receive outputs change only on the edge that captures rx_done, and hold their values otherwise.
- R8: An all-zero received word sets rx_end_mark=1 and does not raise rx_crc_err. Any non-zero word clears rx_end_mark.
- R9: rx_is_cell is 1 only for a conversion-layout word whose channel rx_word[26:23] is at most CELL_LAST (default 5).
- R10: Reset is synchronous and active high. After reset, every registered receive output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_dev | input | 5 | Target device address for the write word |
| tx_reg | input | 6 | Target register address |
| tx_data | input | 8 | Value to write |
| tx_bcast | input | 1 | Broadcast to all devices |
| tx_word | output | 32 | Complete write word |
| rx_word | input | 32 | Captured receive word |
| rx_done | input | 1 | rx_word is complete this cycle |
| rx_regmode | input | 1 | 1: readback layout, 0: conversion layout |
| rx_valid | output | 1 | One-cycle strobe for new receive results |
| rx_crc_err | output | 1 | CRC mismatch on the last word |
| rx_end_mark | output | 1 | Last word was all zero |
| rx_dev | output | 5 | Device address, natural bit order |
| rx_addr | output | 6 | Channel or register address |
| rx_value | output | 12 | Conversion value or readback data |
| rx_ack | output | 1 | Write-acknowledge bit (readback layout) |
| rx_is_cell | output | 1 | Conversion result of a cell-voltage channel |

## Verification
The bench targets the following corner cases:

- **Known write word.** A broadcast-free write to device 0x1F with all-zero fields must yield 0xF800030A. A design that includes the trailer in the CRC, or covers the wrong bit span, produces a different CRC byte.
- **Single-bit corruption.** Received words are corrupted by one bit, in the payload and in the CRC byte. A design that checks the CRC over bits 31:11 instead of 31:10 misses a flipped bit 10.
- **All-zero word.** This is the end-of-chain case. A plain CRC check would still pass it, but a design that fails to treat it separately would not raise the end marker.
- **Asymmetric device addresses and edge channels.** Device addresses with asymmetric bits expose a missing bit reversal. The channel pair 5/6 exposes an off-by-one in the cell flag. Changing the word without a strobe exposes outputs that follow rx_word directly.

// File: rtl/chain_frame_codec.sv
module chain_frame_codec #(
  parameter int CELL_LAST = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  tx_dev,
  input  logic [5:0]  tx_reg,
  input  logic [7:0]  tx_data,
  input  logic        tx_bcast,
  output logic [31:0] tx_word,
  input  logic [31:0] rx_word,
  input  logic        rx_done,
  input  logic        rx_regmode,
  output logic        rx_valid,
  output logic        rx_crc_err,
  output logic        rx_end_mark,
  output logic [4:0]  rx_dev,
  output logic [5:0]  rx_addr,
  output logic [11:0] rx_value,
  output logic        rx_ack,
  output logic        rx_is_cell
);
  localparam logic [7:0] POLY    = 8'h2F;
  localparam logic [2:0] TRAILER = 3'b010;

  function automatic logic [7:0] byte_step(input logic [7:0] b);
    logic [7:0] c;
    c = b;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ POLY) : (c << 1);
    return c;
  endfunction

  function automatic logic [7:0] frame_crc(input logic [23:0] op);
    return byte_step(byte_step(op[23:16]) ^ op[15:8]) ^ op[7:0];
  endfunction

  logic [19:0] hdr;
  logic [7:0]  tx_crc, rx_crc;
  logic [4:0]  dev_nat;

  assign hdr     = {tx_dev, tx_reg, tx_data, tx_bcast};
  assign tx_crc  = frame_crc({3'b000, hdr, 1'b0});
  assign tx_word = {hdr, 1'b0, tx_crc, TRAILER};
  assign rx_crc  = frame_crc({2'b00, rx_word[31:10]});

  always_comb
    for (int i = 0; i < 5; i++) dev_nat[i] = rx_word[31-i];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid    <= 1'b0;
      rx_crc_err  <= 1'b0;
      rx_end_mark <= 1'b0;
      rx_dev      <= '0;
      rx_addr     <= '0;
      rx_value    <= '0;
      rx_ack      <= 1'b0;
      rx_is_cell  <= 1'b0;
    end else begin
      rx_valid <= rx_done;
      if (rx_done) begin
        rx_end_mark <= (rx_word == 32'd0);
        rx_crc_err  <= (rx_word != 32'd0) && (rx_crc != rx_word[9:2]);
        rx_dev      <= dev_nat;
        if (rx_regmode) begin
          rx_addr    <= rx_word[26:21];
          rx_value   <= {4'b0000, rx_word[20:13]};
          rx_ack     <= rx_word[10];
          rx_is_cell <= 1'b0;
        end else begin
          rx_addr    <= {2'b00, rx_word[26:23]};
          rx_value   <= rx_word[22:11];
          rx_ack     <= 1'b0;
          rx_is_cell <= (32'(rx_word[26:23]) <= CELL_LAST);
        end
      end
    end
  end
endmodule

// File: rtl/chain_frame_codec_chk.sv
module chain_frame_codec_chk (
  input logic        clk,
  input logic        rst,
  input logic        rx_done,
  input logic        rx_valid,
  input logic        rx_crc_err,
  input logic        rx_end_mark,
  input logic [11:0] rx_value,
  input logic [5:0]  rx_addr,
  input logic        rx_ack,
  input logic        rx_is_cell
);
  // R7
  strobe_follows_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> rx_valid);
  // R7
  no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_done |=> !rx_valid);
  // R7
  hold_results_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_done |=> ($stable(rx_crc_err) && $stable(rx_value) && $stable(rx_addr)));
  // R8
  end_not_error_chk: assert property (@(posedge clk) disable iff (rst)
    rx_end_mark |-> !rx_crc_err);
  // R8
  end_fields_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rx_end_mark |-> (rx_value == 12'd0 && rx_addr == 6'd0 && !rx_ack));
  // R9
  cell_only_conv_chk: assert property (@(posedge clk) disable iff (rst)
    rx_is_cell |-> (!rx_ack && rx_addr[5:4] == 2'b00));
endmodule

bind chain_frame_codec chain_frame_codec_chk chk_i (
  .clk(clk), .rst(rst), .rx_done(rx_done), .rx_valid(rx_valid),
  .rx_crc_err(rx_crc_err), .rx_end_mark(rx_end_mark), .rx_value(rx_value),
  .rx_addr(rx_addr), .rx_ack(rx_ack), .rx_is_cell(rx_is_cell)
);

// File: tb/chain_frame_codec_tb_top.sv
module chain_frame_codec_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  tx_dev;
  logic [5:0]  tx_reg;
  logic [7:0]  tx_data;
  logic        tx_bcast;
  logic [31:0] tx_word;
  logic [31:0] rx_word;
  logic        rx_done;
  logic        rx_regmode;
  logic        rx_valid, rx_crc_err, rx_end_mark, rx_ack, rx_is_cell;
  logic [4:0]  rx_dev;
  logic [5:0]  rx_addr;
  logic [11:0] rx_value;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chain_frame_codec dut_i (
    .clk(clk), .rst(rst), .tx_dev(tx_dev), .tx_reg(tx_reg), .tx_data(tx_data),
    .tx_bcast(tx_bcast), .tx_word(tx_word), .rx_word(rx_word), .rx_done(rx_done),
    .rx_regmode(rx_regmode), .rx_valid(rx_valid), .rx_crc_err(rx_crc_err),
    .rx_end_mark(rx_end_mark), .rx_dev(rx_dev), .rx_addr(rx_addr),
    .rx_value(rx_value), .rx_ack(rx_ack), .rx_is_cell(rx_is_cell)
  );

  // Serial reference: CRC of the upper 16 bits, then XOR with the low byte
  function automatic logic [7:0] ref_crc(input logic [23:0] op);
    logic [7:0] c = 8'h00;
    logic fb;
    for (int i = 23; i >= 8; i--) begin
      fb = c[7] ^ op[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h2F;
    end
    return c ^ op[7:0];
  endfunction

  function automatic logic [4:0] rev5(input logic [4:0] v);
    return {v[0], v[1], v[2], v[3], v[4]};
  endfunction

  function automatic logic [31:0] seal(input logic [31:0] w);
    logic [31:0] r = w;
    r[9:2] = ref_crc({2'b00, w[31:10]});
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic mode);
    @(negedge clk);
    rx_word = w; rx_regmode = mode; rx_done = 1'b1;
    @(negedge clk);
    rx_done = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; rx_done = 1'b0; rx_word = 32'hFFFF_FFFF; rx_regmode = 1'b1;
    tx_dev = '0; tx_reg = '0; tx_data = '0; tx_bcast = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 valid", {31'd0, rx_valid}, 0);
    chk("R10 fields", {rx_crc_err, rx_end_mark, rx_ack, rx_is_cell, rx_dev, rx_addr, rx_value}, 0);
    rst = 1'b0;
  endtask

  task automatic t_tx_golden();
    tx_dev = 5'h1F; tx_reg = 6'h00; tx_data = 8'h00; tx_bcast = 1'b0;
    #1 chk("R1 known word", tx_word, 32'hF800030A);
  endtask

  task automatic t_tx_patterns();
    logic [31:0] e;
    logic [4:0] d [3] = '{5'h00, 5'h0B, 5'h13};
    logic [5:0] r [3] = '{6'h0D, 6'h1C, 6'h3F};
    logic [7:0] v [3] = '{8'hA5, 8'h00, 8'hFF};
    for (int k = 0; k < 3; k++) begin
      tx_dev = d[k]; tx_reg = r[k]; tx_data = v[k]; tx_bcast = k[0];
      e = {d[k], r[k], v[k], k[0], 12'd0};
      e[10:3] = ref_crc({3'b000, e[31:11]});
      e[2:0] = 3'b010;
      #1 chk("R2 write layout", tx_word, e);
      chk("R1 write crc", {24'd0, tx_word[10:3]}, {24'd0, e[10:3]});
    end
  endtask

  task automatic t_conv();
    logic [31:0] w = 32'd0;
    w[31:27] = rev5(5'h03); w[26:23] = 4'd2; w[22:11] = 12'hABC;
    w = seal(w);
    send(w, 1'b0);
    chk("R7 strobe", {31'd0, rx_valid}, 1);
    chk("R3 good crc", {31'd0, rx_crc_err}, 0);
    chk("R4 chan", {26'd0, rx_addr}, 2);
    chk("R4 value", {20'd0, rx_value}, 32'hABC);
    chk("R4 ack zero", {31'd0, rx_ack}, 0);
    chk("R6 dev", {27'd0, rx_dev}, 3);
    @(negedge clk);
    chk("R7 single cycle", {31'd0, rx_valid}, 0);
  endtask

  task automatic t_readback();
    logic [31:0] w = 32'd0;
    w[31:27] = rev5(5'h01); w[26:21] = 6'h0E; w[20:13] = 8'h5A; w[10] = 1'b1;
    w = seal(w);
    send(w, 1'b1);
    chk("R5 reg", {26'd0, rx_addr}, 32'h0E);
    chk("R5 data", {20'd0, rx_value}, 32'h5A);
    chk("R5 ack", {31'd0, rx_ack}, 1);
    chk("R6 dev reversed", {27'd0, rx_dev}, 1);
    chk("R9 readback not cell", {31'd0, rx_is_cell}, 0);
    chk("R3 good crc readback", {31'd0, rx_crc_err}, 0);
  endtask

  task automatic t_crc_err();
    logic [31:0] w = 32'd0;
    w[31:27] = 5'h06; w[26:23] = 4'd7; w[22:11] = 12'h123;
    w = seal(w);
    send(w ^ 32'h0000_0400, 1'b0);
    chk("R3 bit10 flip", {31'd0, rx_crc_err}, 1);
    send(w ^ 32'h0000_0004, 1'b0);
    chk("R3 crc flip", {31'd0, rx_crc_err}, 1);
    send(w ^ 32'h0001_0000, 1'b0);
    chk("R3 data flip", {31'd0, rx_crc_err}, 1);
    send(w, 1'b0);
    chk("R3 clean", {31'd0, rx_crc_err}, 0);
  endtask

  task automatic t_end_mark();
    send(32'd0, 1'b0);
    chk("R8 end mark", {31'd0, rx_end_mark}, 1);
    chk("R8 no crc err", {31'd0, rx_crc_err}, 0);
    send(seal(32'h0800_0000), 1'b0);
    chk("R8 cleared", {31'd0, rx_end_mark}, 0);
  endtask

  task automatic t_cell_bound();
    logic [31:0] w = 32'd0;
    w[26:23] = 4'd5; w[22:11] = 12'h800;
    send(seal(w), 1'b0);
    chk("R9 channel 5 cell", {31'd0, rx_is_cell}, 1);
    w[26:23] = 4'd6;
    send(seal(w), 1'b0);
    chk("R9 channel 6 aux", {31'd0, rx_is_cell}, 0);
  endtask

  task automatic t_hold();
    logic [31:0] w = 32'd0;
    w[31:27] = rev5(5'h04); w[26:23] = 4'd9; w[22:11] = 12'h0F0;
    send(seal(w), 1'b0);
    @(negedge clk);
    rx_word = 32'h1234_5679; rx_regmode = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 hold value", {20'd0, rx_value}, 32'h0F0);
    chk("R7 hold addr", {26'd0, rx_addr}, 9);
    chk("R7 hold dev", {27'd0, rx_dev}, 4);
    chk("R7 no strobe", {31'd0, rx_valid}, 0);
  endtask

  initial begin
    t_reset();
    t_tx_golden();
    t_tx_patterns();
    t_conv();
    t_readback();
    t_crc_err();
    t_end_mark();
    t_cell_bound();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule